// File: doc/BRIEF.md
# Packet Queue Interrupt Controller

This block keeps three short first-in first-out queues of packet numbers. The transmit queue holds packets waiting to be sent. The completion queue holds packets that the transmit engine has finished. The receive queue holds packets that have arrived. A command unit and a transmit engine push entries and take them out. Each queue shows its head entry at a port, and an empty queue shows a fixed code in place of a head.

The block also keeps an 8-bit latched status byte and an 8-bit mask byte, and it drives one interrupt line from the two. Single-cycle event inputs, queue activity and the state of the queues set bits in the status byte. Software clears bits through an acknowledge write. Two of the status bits follow the queues. On every clock edge, the transmit-empty bit is set again if the transmit queue is empty, and the transmit bit is set again if the completion queue holds any entry. When software acknowledges the transmit bit, the oldest completion entry is removed.

Every state change takes effect on the rising clock edge after the request. The interrupt line is built from registered status and mask only.

Top module: `pq_irq_ctrl`

## Requirements
- R1: After reset, the status byte is 0x04, the mask byte is 0x00, `irq` is low, and all three heads read 0x80.
- R2: Each queue holds up to 4 packet numbers in arrival order and presents the oldest at its head port. A push to a full queue is ignored and a pop from an empty queue is ignored. When a push and a pop reach the same queue in one cycle, the pop is done first, so a full queue accepts the new entry.
- R3: A head port whose queue is empty reads 0x80. Otherwise it reads the packet number with zeros in the upper bits.
- R4: After every clock edge, status bit 2 (value 0x04, transmit empty) is 1 if the transmit queue is empty. While the queue is not empty, the bit keeps its latched value.
- R5: After every clock edge, status bit 1 (value 0x02, transmit) is 1 if the completion queue holds at least one entry.
- R6: An acknowledge write with value V clears exactly the status bits that are set in V AND 0xD6. Bits 0x01, 0x08 and 0x20 never change because of an acknowledge write.
- R7: An acknowledge write with bit 1 set removes one entry from the completion queue, if the queue has one.
- R8: A receive push sets status bit 0 (value 0x01, receive). After a receive pop, bit 0 is 1 if entries remain and 0 if the queue is now empty. The same rule applies when a pop is made on an already empty queue.
- R9: An `set_alloc` pulse sets status bit 3 (0x08), and an `set_ovrn` pulse sets status bit 4 (0x10). If an acknowledge write in the same cycle covers the same bit, the set wins.
- R10: `irq` is high exactly when the status byte AND the mask byte is non-zero. A mask write replaces the whole mask byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_push | input | 1 | Append `tx_push_num` to the transmit queue |
| tx_push_num | input | 6 | Packet number for the transmit queue |
| tx_pop | input | 1 | Transmit engine takes the transmit queue head |
| done_push | input | 1 | Append `done_push_num` to the completion queue |
| done_push_num | input | 6 | Packet number of a finished transmission |
| rx_push | input | 1 | Append `rx_push_num` to the receive queue |
| rx_push_num | input | 6 | Packet number of a received frame |
| rx_pop | input | 1 | Remove the receive queue head |
| set_alloc | input | 1 | Set the allocation-complete status bit |
| set_ovrn | input | 1 | Set the receive-overrun status bit |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Acknowledge value |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask byte |
| tx_head | output | 8 | Transmit queue head, or 0x80 when the queue is empty |
| done_head | output | 8 | Completion queue head, or 0x80 when the queue is empty |
| rx_head | output | 8 | Receive queue head, or 0x80 when the queue is empty |
| status | output | 8 | Latched status byte |
| irq | output | 1 | Interrupt request |

## Verification
The main collision is between an acknowledge write and queue activity in the same cycle. One case is an acknowledge of the transmit bit that pops the completion queue while the transmit engine pushes a new entry, so the transmit bit must come back on. Another is an acknowledge of the overrun or transmit-empty bit in the same cycle as the event that sets that bit. Directed steps force each of these pairs, and random traffic with biased strobes makes them happen many more times. A reference model in the bench judges every cycle. It applies pops before pushes, applies the acknowledge clear before any set, and derives the queue-based bits last.

// File: rtl/pqic_pkg.sv
package pqic_pkg;
    localparam int unsigned STAT_W = 8;

    localparam logic [STAT_W-1:0] BIT_RX    = 8'h01;
    localparam logic [STAT_W-1:0] BIT_TX    = 8'h02;
    localparam logic [STAT_W-1:0] BIT_TXE   = 8'h04;
    localparam logic [STAT_W-1:0] BIT_ALLOC = 8'h08;
    localparam logic [STAT_W-1:0] BIT_OVRN  = 8'h10;
    localparam logic [STAT_W-1:0] ACK_MASK  = 8'hD6;
    localparam logic [STAT_W-1:0] RESET_ST  = 8'h04;
    localparam logic [STAT_W-1:0] EMPTY_CODE = 8'h80;

    // queue indices used by the generate loop in the top
    localparam int unsigned Q_TX   = 0;
    localparam int unsigned Q_DONE = 1;
    localparam int unsigned Q_RX   = 2;
    localparam int unsigned NUM_Q  = 3;

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [STAT_W-1:0] mask;
    } ctl_t;
endpackage

// File: rtl/pq_fifo.sv
module pq_fifo #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PKT_W  = 6,
    parameter int unsigned HEAD_W = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PKT_W-1:0]  push_num,
    input  logic              pop,
    output logic [HEAD_W-1:0] head,
    output logic [CNT_W-1:0]  cnt_d
);
    import pqic_pkg::*;

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][PKT_W-1:0] ent;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t cur_q, nxt_d;
    logic [CNT_W-1:0] mid_cnt;

    always_comb begin
        nxt_d   = cur_q;
        mid_cnt = cur_q.cnt;
        // pop first: shift every entry one slot toward the head
        if (pop && (cur_q.cnt != '0)) begin
            for (int i = 0; i < int'(DEPTH) - 1; i++) begin
                nxt_d.ent[i] = cur_q.ent[i+1];
            end
            nxt_d.ent[DEPTH-1] = '0;
            mid_cnt = cur_q.cnt - CNT_W'(1);
        end
        nxt_d.cnt = mid_cnt;
        // then push into the first free slot
        if (push && (mid_cnt < FULL)) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (CNT_W'(i) == mid_cnt) begin
                    nxt_d.ent[i] = push_num;
                end
            end
            nxt_d.cnt = mid_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cnt_d = nxt_d.cnt;
    assign head  = (cur_q.cnt == '0) ? HEAD_W'(EMPTY_CODE)
                                     : {{(HEAD_W-PKT_W){1'b0}}, cur_q.ent[0]};
endmodule

// File: rtl/pq_status.sv
module pq_status (
    input  logic [7:0] status_q,
    input  logic       ack_we,
    input  logic [7:0] ack_data,
    input  logic       rx_push,
    input  logic       rx_pop,
    input  logic       rx_left,
    input  logic       set_alloc,
    input  logic       set_ovrn,
    input  logic       tx_empty,
    input  logic       done_busy,
    output logic [7:0] status_d
);
    import pqic_pkg::*;

    always_comb begin
        status_d = status_q;
        // acknowledge clears first, so that every set below wins
        if (ack_we) begin
            status_d = status_d & ~(ack_data & ACK_MASK);
        end
        if (rx_pop) begin
            status_d = rx_left ? (status_d | BIT_RX) : (status_d & ~BIT_RX);
        end
        if (rx_push)   status_d = status_d | BIT_RX;
        if (set_alloc) status_d = status_d | BIT_ALLOC;
        if (set_ovrn)  status_d = status_d | BIT_OVRN;
        // bits that follow the queues are reapplied last
        if (tx_empty)  status_d = status_d | BIT_TXE;
        if (done_busy) status_d = status_d | BIT_TX;
    end
endmodule

// File: rtl/pq_irq_ctrl.sv
module pq_irq_ctrl #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PKT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_push,
    input  logic [PKT_W-1:0] tx_push_num,
    input  logic             tx_pop,
    input  logic             done_push,
    input  logic [PKT_W-1:0] done_push_num,
    input  logic             rx_push,
    input  logic [PKT_W-1:0] rx_push_num,
    input  logic             rx_pop,
    input  logic             set_alloc,
    input  logic             set_ovrn,
    input  logic             ack_we,
    input  logic [7:0]       ack_data,
    input  logic             mask_we,
    input  logic [7:0]       mask_data,
    output logic [7:0]       tx_head,
    output logic [7:0]       done_head,
    output logic [7:0]       rx_head,
    output logic [7:0]       status,
    output logic             irq
);
    import pqic_pkg::*;

    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [NUM_Q-1:0]            push_v, pop_v;
    logic [NUM_Q-1:0][PKT_W-1:0] num_v;
    logic [NUM_Q-1:0][7:0]       head_v;
    logic [NUM_Q-1:0][CNT_W-1:0] cnt_v;

    ctl_t ctl_q, ctl_d;
    logic [7:0] status_nx;

    assign push_v[Q_TX]   = tx_push;
    assign push_v[Q_DONE] = done_push;
    assign push_v[Q_RX]   = rx_push;
    assign num_v[Q_TX]    = tx_push_num;
    assign num_v[Q_DONE]  = done_push_num;
    assign num_v[Q_RX]    = rx_push_num;
    assign pop_v[Q_TX]    = tx_pop;
    assign pop_v[Q_DONE]  = ack_we && ack_data[1];
    assign pop_v[Q_RX]    = rx_pop;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        pq_fifo #(.DEPTH(DEPTH), .PKT_W(PKT_W), .HEAD_W(8)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (push_v[g]),
            .push_num (num_v[g]),
            .pop      (pop_v[g]),
            .head     (head_v[g]),
            .cnt_d    (cnt_v[g])
        );
    end

    pq_status u_status (
        .status_q  (ctl_q.status),
        .ack_we    (ack_we),
        .ack_data  (ack_data),
        .rx_push   (rx_push),
        .rx_pop    (rx_pop),
        .rx_left   (cnt_v[Q_RX] != '0),
        .set_alloc (set_alloc),
        .set_ovrn  (set_ovrn),
        .tx_empty  (cnt_v[Q_TX] == '0),
        .done_busy (cnt_v[Q_DONE] != '0),
        .status_d  (status_nx)
    );

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.status = status_nx;
        if (mask_we) ctl_d.mask = mask_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.status <= RESET_ST;
            ctl_q.mask   <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_head   = head_v[Q_TX];
    assign done_head = head_v[Q_DONE];
    assign rx_head   = head_v[Q_RX];
    assign status    = ctl_q.status;
    assign irq       = |(ctl_q.status & ctl_q.mask);
endmodule

// File: rtl/pq_irq_ctrl_chk.sv
module pq_irq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] status,
    input logic [7:0] mask,
    input logic       irq,
    input logic [7:0] tx_head,
    input logic [7:0] done_head,
    input logic [7:0] rx_head,
    input logic       ack_we,
    input logic       rx_pop,
    input logic       set_ovrn
);
    // R4
    txe_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_head == 8'h80) |-> status[2]);

    // R5
    tx_bit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_head != 8'h80) |-> status[1]);

    // R8
    rx_bit_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] == (rx_head != 8'h80));

    // R6
    ack_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && status[0] && !rx_pop) |=> status[0]);

    // R9
    ovrn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_ovrn |=> status[4]);

    // R10
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((status & mask) != 8'h00));
endmodule

bind pq_irq_ctrl pq_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status),
    .mask      (ctl_q.mask),
    .irq       (irq),
    .tx_head   (tx_head),
    .done_head (done_head),
    .rx_head   (rx_head),
    .ack_we    (ack_we),
    .rx_pop    (rx_pop),
    .set_ovrn  (set_ovrn)
);

// File: tb/pq_irq_ctrl_tb.sv
module pq_irq_ctrl_tb;
    localparam int DEPTH = 4;
    localparam int PKT_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic             tx_push = 0, tx_pop = 0, done_push = 0, rx_push = 0, rx_pop = 0;
    logic [PKT_W-1:0] tx_push_num = '0, done_push_num = '0, rx_push_num = '0;
    logic             set_alloc = 0, set_ovrn = 0, ack_we = 0, mask_we = 0;
    logic [7:0]       ack_data = '0, mask_data = '0;
    logic [7:0]       tx_head, done_head, rx_head, status;
    logic             irq;

    pq_irq_ctrl #(.DEPTH(DEPTH), .PKT_W(PKT_W)) u_dut (.*);

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model
    int         mq [3][DEPTH];
    int         mc [3];
    logic [7:0] mst, mmask;

    function automatic void m_pop(int q);
        if (mc[q] > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) mq[q][i] = mq[q][i+1];
            mc[q]--;
        end
    endfunction

    function automatic void m_push(int q, int v);
        if (mc[q] < DEPTH) begin
            mq[q][mc[q]] = v;
            mc[q]++;
        end
    endfunction

    function automatic logic [7:0] m_head(int q);
        return (mc[q] == 0) ? 8'h80 : 8'(mq[q][0]);
    endfunction

    function automatic void m_reset();
        for (int q = 0; q < 3; q++) mc[q] = 0;
        mst = 8'h04;
        mmask = 8'h00;
    endfunction

    function automatic void m_step();
        if (tx_pop) m_pop(0);
        if (ack_we && ack_data[1]) m_pop(1);
        if (rx_pop) m_pop(2);
        if (tx_push) m_push(0, int'(tx_push_num));
        if (done_push) m_push(1, int'(done_push_num));
        if (rx_push) m_push(2, int'(rx_push_num));
        if (ack_we) mst = mst & ~(ack_data & 8'hD6);
        if (rx_pop) mst[0] = (mc[2] != 0);
        if (rx_push) mst[0] = 1'b1;
        if (set_alloc) mst[3] = 1'b1;
        if (set_ovrn) mst[4] = 1'b1;
        if (mc[0] == 0) mst[2] = 1'b1;
        if (mc[1] != 0) mst[1] = 1'b1;
        if (mask_we) mmask = mask_data;
    endfunction

    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "tx_head", tx_head, m_head(0));
        chk(tag, "done_head", done_head, m_head(1));
        chk(tag, "rx_head", rx_head, m_head(2));
        chk(tag, "status", status, mst);
        chk(tag, "irq", {7'd0, irq}, {7'd0, ((mst & mmask) != 8'h00)});
    endtask

    task automatic clear_in();
        tx_push = 0; tx_pop = 0; done_push = 0; rx_push = 0; rx_pop = 0;
        set_alloc = 0; set_ovrn = 0; ack_we = 0; mask_we = 0;
        ack_data = '0; mask_data = '0;
    endtask

    // inputs already set at a negedge; advance one edge and compare
    task automatic step(string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        clear_in();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        compare_all("R1");
        chk("R1", "status literal", status, 8'h04);

        // R2 fill transmit queue past its depth, R6 clear TXE while busy
        for (int i = 0; i < 5; i++) begin
            tx_push = 1; tx_push_num = 6'(10 + i);
            step("R2");
        end
        ack_we = 1; ack_data = 8'h04;
        step("R6");
        chk("R6", "txe cleared", {7'd0, status[2]}, 8'h00);
        // R2 push and pop together on a full queue
        tx_push = 1; tx_push_num = 6'd33; tx_pop = 1;
        step("R2");
        for (int i = 0; i < 5; i++) begin
            tx_pop = 1;
            step("R2");
        end
        // R4 transmit-empty comes back once drained
        chk("R4", "txe bit", {7'd0, status[2]}, 8'h01);
        chk("R3", "tx empty head", tx_head, 8'h80);

        // R5 / R7 completion queue and acknowledge pop
        done_push = 1; done_push_num = 6'd5;
        step("R5");
        done_push = 1; done_push_num = 6'd6;
        step("R5");
        ack_we = 1; ack_data = 8'h02;
        step("R7");
        chk("R7", "done head after one ack", done_head, 8'h06);
        chk("R5", "tx bit remains", {7'd0, status[1]}, 8'h01);
        // acknowledge pop in the same cycle as a new completion
        ack_we = 1; ack_data = 8'h02; done_push = 1; done_push_num = 6'd7;
        step("R7");
        ack_we = 1; ack_data = 8'h02;
        step("R7");
        chk("R3", "done empty head", done_head, 8'h80);
        chk("R5", "tx bit cleared", {7'd0, status[1]}, 8'h00);

        // R8 receive bit
        rx_push = 1; rx_push_num = 6'd20;
        step("R8");
        rx_push = 1; rx_push_num = 6'd21;
        step("R8");
        rx_pop = 1;
        step("R8");
        chk("R8", "rx bit with entry left", {7'd0, status[0]}, 8'h01);
        // R6 acknowledge of all ones leaves receive and allocation bits
        set_alloc = 1;
        step("R9");
        ack_we = 1; ack_data = 8'hFF;
        step("R6");
        chk("R6", "rx and alloc kept", status & 8'h29, 8'h09);
        rx_pop = 1;
        step("R8");
        chk("R8", "rx bit cleared", {7'd0, status[0]}, 8'h00);
        rx_pop = 1;
        step("R2");

        // R9 set beats same-cycle acknowledge
        set_ovrn = 1; ack_we = 1; ack_data = 8'h10;
        step("R9");
        chk("R9", "ovrn set wins", {7'd0, status[4]}, 8'h01);

        // R10 mask and interrupt
        mask_we = 1; mask_data = 8'h10;
        step("R10");
        chk("R10", "irq high", {7'd0, irq}, 8'h01);
        ack_we = 1; ack_data = 8'h10;
        step("R10");
        chk("R10", "irq low", {7'd0, irq}, 8'h00);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            tx_push = ($urandom % 100) < 40;   tx_push_num = 6'($urandom);
            tx_pop = ($urandom % 100) < 30;
            done_push = ($urandom % 100) < 30; done_push_num = 6'($urandom);
            rx_push = ($urandom % 100) < 35;   rx_push_num = 6'($urandom);
            rx_pop = ($urandom % 100) < 30;
            set_alloc = ($urandom % 100) < 10;
            set_ovrn = ($urandom % 100) < 10;
            ack_we = ($urandom % 100) < 30;    ack_data = 8'($urandom);
            mask_we = ($urandom % 100) < 10;   mask_data = 8'($urandom);
            step("R2 R5 R6 R7 R8 R10");
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule